// File: doc/BRIEF.md
# Eight-Point Streaming Radix-2 FFT

This block computes a complex 8-point discrete Fourier transform with a decimation-in-time radix-2 datapath. A producer streams one frame into it. A frame holds eight complex samples in natural time order, followed by four complex weights. The block has no sine or cosine tables, so the weights must come from the stream. Results leave on a second stream as eight complex bins in natural frequency order. The block does the bit-reversed placement itself, as samples are written into storage, so neither side has to reorder anything.

Real and imaginary parts are held in separate register arrays. A frame runs through three stages, and each stage takes one clock. The four butterflies of a stage operate in parallel. Every butterfly halves its two results, so the transform that comes out is the DFT divided by 8.

While a frame is being computed or read out, the input handshake stays closed. A new frame therefore cannot overwrite results that have not yet been delivered.

Top module: `fft8_stream`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: A frame is exactly 12 input transfers, each completed on a rising edge where `in_valid` and `in_ready` are both 1. Transfers 0 to 7 carry samples x[0] to x[7]. Transfers 8 to 11 carry weights W0 to W3 as signed fixed-point values with FRAC fractional bits.
- R3: Output transfer k (k = 0 to 7) carries X[k] = (1/8)·Σ x[n]·W(nk mod 8), to within 4 LSB on each of the real and imaginary parts. Here W(m) is the supplied Wm for m < 4, and W(m) = −W(m−4) otherwise.
- R4: The weights are taken only from the stream. If conjugated weights are supplied, the block returns the inverse transform divided by 8 under the same R3 formula.
- R5: From the edge that accepts the 12th transfer until the edge that accepts the 8th output, `in_ready` is 0, and a held `in_valid` is not consumed.
- R6: `out_valid` first rises on the third rising edge after the edge that accepted the 12th input transfer.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re`, `out_im` and `out_last` hold their values into the next cycle.
- R8: `out_last` is 1 exactly during the output transfer that carries X[7].
- R9: `in_ready` returns to 1 in the cycle after the 8th output is accepted, and the next frame is then taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept an input word |
| in_re | input | DW | Real part of sample or weight |
| in_im | input | DW | Imaginary part of sample or weight |
| out_valid | output | 1 | Result bin present |
| out_ready | input | 1 | Consumer accepts the bin |
| out_re | output | DW | Real part of result bin |
| out_im | output | DW | Imaginary part of result bin |
| out_last | output | 1 | Marks bin 7 of a frame |

## Verification
The first bin of a frame is due three edges after the edge that accepted the last weight. Later bins are due one per edge on which `out_ready` is high. The bench notes the cycle of the final input acceptance and compares the first `out_valid` against it. Every bin is then compared against a queue of reference values, sampled on the falling edge that comes before the transfer edge. The input-closed window is judged when the eighth bin is taken, and the reopening is judged one falling edge later.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
   localparam int NPT       = 8;
   localparam int LG        = $clog2(NPT);
   localparam int NTW       = NPT / 2;
   localparam int NSTG      = LG;
   localparam int FRAME_LEN = NPT + NTW;

   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_CALC = 2'd1,
      ST_SEND = 2'd2
   } fft_state_t;

   function automatic logic [LG-1:0] bit_rev(input logic [LG-1:0] v);
      logic [LG-1:0] r;
      for (int i = 0; i < LG; i++) r[i] = v[LG-1-i];
      return r;
   endfunction
endpackage

// File: rtl/fft8_bfly.sv
module fft8_bfly #(
   parameter int DW   = 16,
   parameter int TW   = 16,
   parameter int FRAC = 14
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   input  logic signed [TW-1:0] w_re,
   input  logic signed [TW-1:0] w_im,
   output logic signed [DW-1:0] p_re,
   output logic signed [DW-1:0] p_im,
   output logic signed [DW-1:0] q_re,
   output logic signed [DW-1:0] q_im
);
   localparam int PW = DW + TW + 2;

   if (FRAC >= TW) begin : g_bad_frac
      $error("fft8_bfly: FRAC must be below TW");
   end

   logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
   logic signed [PW-1:0] t_re, t_im;
   logic signed [PW-1:0] s_p_re, s_p_im, s_q_re, s_q_im;

   always_comb begin
      m_rr   = PW'(b_re) * PW'(w_re);
      m_ii   = PW'(b_im) * PW'(w_im);
      m_ri   = PW'(b_re) * PW'(w_im);
      m_ir   = PW'(b_im) * PW'(w_re);
      t_re   = (m_rr - m_ii) >>> FRAC;
      t_im   = (m_ri + m_ir) >>> FRAC;
      s_p_re = (PW'(a_re) + t_re) >>> 1;
      s_p_im = (PW'(a_im) + t_im) >>> 1;
      s_q_re = (PW'(a_re) - t_re) >>> 1;
      s_q_im = (PW'(a_im) - t_im) >>> 1;
      p_re   = s_p_re[DW-1:0];
      p_im   = s_p_im[DW-1:0];
      q_re   = s_q_re[DW-1:0];
      q_im   = s_q_im[DW-1:0];
   end
endmodule

// File: rtl/fft8_stage.sv
module fft8_stage
   import fft8_pkg::*;
#(
   parameter int DW   = 16,
   parameter int TW   = 16,
   parameter int FRAC = 14,
   parameter int SPAN = 1
) (
   input  logic [NPT-1:0][DW-1:0] x_re,
   input  logic [NPT-1:0][DW-1:0] x_im,
   input  logic [NTW-1:0][TW-1:0] w_re,
   input  logic [NTW-1:0][TW-1:0] w_im,
   output logic [NPT-1:0][DW-1:0] y_re,
   output logic [NPT-1:0][DW-1:0] y_im
);
   localparam int WSTEP = NPT / (2 * SPAN);

   if (SPAN < 1 || SPAN > NPT / 2 || (SPAN & (SPAN - 1)) != 0) begin : g_bad_span
      $error("fft8_stage: SPAN must be a power of two up to NPT/2");
   end

   for (genvar j = 0; j < NPT / 2; j++) begin : g_bf
      localparam int POS  = j % SPAN;
      localparam int GRP  = j / SPAN;
      localparam int TOPI = GRP * 2 * SPAN + POS;
      localparam int BOTI = TOPI + SPAN;
      localparam int KW   = POS * WSTEP;

      fft8_bfly #(.DW(DW), .TW(TW), .FRAC(FRAC)) u_bfly (
         .a_re (x_re[TOPI]),
         .a_im (x_im[TOPI]),
         .b_re (x_re[BOTI]),
         .b_im (x_im[BOTI]),
         .w_re (w_re[KW]),
         .w_im (w_im[KW]),
         .p_re (y_re[TOPI]),
         .p_im (y_im[TOPI]),
         .q_re (y_re[BOTI]),
         .q_im (y_im[BOTI])
      );
   end
endmodule

// File: rtl/fft8_stream.sv
module fft8_stream
   import fft8_pkg::*;
#(
   parameter int DW   = 16,
   parameter int TW   = 16,
   parameter int FRAC = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_re,
   input  logic [DW-1:0] in_im,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_re,
   output logic [DW-1:0] out_im,
   output logic          out_last
);
   localparam int CW = $clog2(FRAME_LEN + 1);
   localparam int SW = $clog2(NSTG + 1);
   localparam int KW = $clog2(NTW);

   if (TW > DW) begin : g_bad_tw
      $error("fft8_stream: weights are carried on the data lanes, TW must not exceed DW");
   end
   if (DW < 4) begin : g_bad_dw
      $error("fft8_stream: DW too small");
   end

   fft_state_t st;
   logic [CW-1:0] cnt;
   logic [SW-1:0] stg;
   logic [NPT-1:0][DW-1:0] mem_re, mem_im;
   logic [NTW-1:0][TW-1:0] tw_re, tw_im;
   logic [NPT-1:0][DW-1:0] nx_re [NSTG];
   logic [NPT-1:0][DW-1:0] nx_im [NSTG];
   logic [LG-1:0] slot;
   logic [KW-1:0] tw_sel;
   logic          take_in;

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      fft8_stage #(.DW(DW), .TW(TW), .FRAC(FRAC), .SPAN(1 << s)) u_stage (
         .x_re (mem_re),
         .x_im (mem_im),
         .w_re (tw_re),
         .w_im (tw_im),
         .y_re (nx_re[s]),
         .y_im (nx_im[s])
      );
   end

   assign slot     = cnt[LG-1:0];
   assign tw_sel   = KW'(cnt - CW'(NPT));
   assign in_ready = (st == ST_LOAD);
   assign take_in  = in_valid && in_ready;
   assign out_valid = (st == ST_SEND);
   assign out_re   = mem_re[slot];
   assign out_im   = mem_im[slot];
   assign out_last = out_valid && (cnt == CW'(NPT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_LOAD;
         cnt    <= '0;
         stg    <= '0;
         mem_re <= '0;
         mem_im <= '0;
         tw_re  <= '0;
         tw_im  <= '0;
      end else begin
         case (st)
            ST_LOAD: begin
               if (take_in) begin
                  if (cnt < CW'(NPT)) begin
                     mem_re[bit_rev(slot)] <= in_re;
                     mem_im[bit_rev(slot)] <= in_im;
                  end else begin
                     tw_re[tw_sel] <= in_re[TW-1:0];
                     tw_im[tw_sel] <= in_im[TW-1:0];
                  end
                  if (cnt == CW'(FRAME_LEN - 1)) begin
                     st  <= ST_CALC;
                     cnt <= '0;
                     stg <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_CALC: begin
               for (int s = 0; s < NSTG; s++) begin
                  if (stg == SW'(s)) begin
                     mem_re <= nx_re[s];
                     mem_im <= nx_im[s];
                  end
               end
               if (stg == SW'(NSTG - 1)) begin
                  st  <= ST_SEND;
                  cnt <= '0;
               end else begin
                  stg <= stg + 1'b1;
               end
            end
            ST_SEND: begin
               if (out_ready) begin
                  if (cnt == CW'(NPT - 1)) begin
                     st  <= ST_LOAD;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: st <= ST_LOAD;
         endcase
      end
   end

   p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready)
      else $error("p_ready_busy_r5");

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)))
      else $error("p_hold_r7");

   p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid)
      else $error("p_last_valid_r8");

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready, 4))
      else $error("p_latency_r6");

   p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cnt == CW'(FRAME_LEN - 1)) |=> !in_ready)
      else $error("p_frame_len_r2");
endmodule

// File: tb/test_fft8_stream.sv
module test_fft8_stream;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int TW = 16;
   localparam int FRAC = 14;
   localparam int TOL = 4;
   localparam int NFRAMES = 6;

   logic clk = 0;
   logic rst_n = 0;
   logic in_valid = 0;
   logic in_ready;
   logic [DW-1:0] in_re = '0;
   logic [DW-1:0] in_im = '0;
   logic out_valid;
   logic out_ready = 1;
   logic [DW-1:0] out_re;
   logic [DW-1:0] out_im;
   logic out_last;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;
   int t_acc = 0;
   int frames_done = 0;
   int out_idx = 0;
   bit busy = 0;
   bit busy_bad = 0;
   bit ready_due = 0;
   bit first_seen = 0;
   bit hold_pending = 0;
   bit bp_mode = 0;
   bit finished = 0;
   logic [DW-1:0] held_re, held_im;
   logic held_last;

   int exp_re[$];
   int exp_im[$];
   string exp_tag[$];

   fft8_stream #(.DW(DW), .TW(TW), .FRAC(FRAC)) i_fft8_stream (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
      .out_re(out_re), .out_im(out_im), .out_last(out_last)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #1;
         out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
      end
   end

   task automatic send(input int re, input int im);
      in_valid = 1;
      in_re = DW'(re);
      in_im = DW'(im);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_frame(input int f, input int xr[8], input int xi[8], input bit conj, input string tag);
      int wr[4];
      int wi[4];
      for (int k = 0; k < 4; k++) begin
         wr[k] = $rtoi($floor($cos(2.0 * 3.14159265358979 * k / 8.0) * (1 << FRAC) + 0.5));
         wi[k] = $rtoi($floor(-$sin(2.0 * 3.14159265358979 * k / 8.0) * (1 << FRAC) + 0.5));
         if (conj) wi[k] = -wi[k];
      end
      for (int k = 0; k < 8; k++) begin
         real ar, ai;
         ar = 0.0;
         ai = 0.0;
         for (int n = 0; n < 8; n++) begin
            int m;
            real cr, ci;
            m = (n * k) % 8;
            if (m < 4) begin
               cr = wr[m];
               ci = wi[m];
            end else begin
               cr = -wr[m - 4];
               ci = -wi[m - 4];
            end
            cr = cr / (1 << FRAC);
            ci = ci / (1 << FRAC);
            ar = ar + xr[n] * cr - xi[n] * ci;
            ai = ai + xr[n] * ci + xi[n] * cr;
         end
         exp_re.push_back($rtoi($floor(ar / 8.0 + 0.5)));
         exp_im.push_back($rtoi($floor(ai / 8.0 + 0.5)));
         exp_tag.push_back(tag);
      end
      for (int n = 0; n < 8; n++) send(xr[n], xi[n]);
      for (int k = 0; k < 4; k++) send(wr[k], wi[k]);
      t_acc = cyc;
      busy = 1;
      busy_bad = 0;
      if (f == NFRAMES - 1) in_valid = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (hold_pending) begin
            check(out_valid && out_re == held_re && out_im == held_im && out_last == held_last,
                  "R7", "held bin changed", int'(out_re), int'(held_re));
            hold_pending = 0;
         end
         if (ready_due) begin
            check(in_ready == 1'b1, "R9", "in_ready after frame", int'(in_ready), 1);
            ready_due = 0;
         end
         if (busy && in_ready) busy_bad = 1;
         if (out_valid) begin
            if (!first_seen) begin
               check(cyc - t_acc == 3, "R6", "first out_valid latency", cyc - t_acc, 3);
               first_seen = 1;
            end
            if (out_ready) begin
               int er, ei, ar, ai;
               string tg;
               er = exp_re.pop_front();
               ei = exp_im.pop_front();
               tg = exp_tag.pop_front();
               ar = int'($signed(out_re));
               ai = int'($signed(out_im));
               check((ar - er <= TOL) && (er - ar <= TOL), tg, $sformatf("bin %0d re", out_idx), ar, er);
               check((ai - ei <= TOL) && (ei - ai <= TOL), tg, $sformatf("bin %0d im", out_idx), ai, ei);
               check(out_last == (out_idx == 7), "R8", $sformatf("out_last at bin %0d", out_idx),
                     int'(out_last), int'(out_idx == 7));
               out_idx++;
               if (out_idx == 8) begin
                  check(!busy_bad, "R5", "in_ready high while busy", int'(busy_bad), 0);
                  busy = 0;
                  ready_due = 1;
                  first_seen = 0;
                  out_idx = 0;
                  frames_done++;
               end
            end else begin
               hold_pending = 1;
               held_re = out_re;
               held_im = out_im;
               held_last = out_last;
            end
         end
      end
   end

   initial begin
      int xr[8];
      int xi[8];
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

      // R2/R3: impulse at x[0] spreads evenly to all bins
      for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[0] = 5000; xi[0] = -3000;
      run_frame(0, xr, xi, 0, "R3");
      // R3: constant input lands in bin 0 only
      for (int n = 0; n < 8; n++) begin xr[n] = 1000; xi[n] = 500; end
      run_frame(1, xr, xi, 0, "R3");
      // R3: single tone at bin 1
      for (int n = 0; n < 8; n++) begin
         xr[n] = $rtoi($floor(3000.0 * $cos(2.0 * 3.14159265358979 * n / 8.0) + 0.5));
         xi[n] = $rtoi($floor(3000.0 * $sin(2.0 * 3.14159265358979 * n / 8.0) + 0.5));
      end
      run_frame(2, xr, xi, 0, "R3");
      // R3 and R7: mixed pattern under output backpressure
      bp_mode = 1;
      for (int n = 0; n < 8; n++) begin
         xr[n] = ((n * 53 + 3 * 29) % 61 - 30) * 250;
         xi[n] = ((n * 17 + 3 * 7) % 43 - 21) * 300;
      end
      run_frame(3, xr, xi, 0, "R3");
      // R4: conjugated weights give the inverse transform
      for (int n = 0; n < 8; n++) begin
         xr[n] = ((n * 53 + 4 * 29) % 61 - 30) * 250;
         xi[n] = ((n * 17 + 4 * 7) % 43 - 21) * 300;
      end
      run_frame(4, xr, xi, 1, "R4");
      bp_mode = 0;
      for (int n = 0; n < 8; n++) begin
         xr[n] = ((n * 41 + 5 * 13) % 59 - 29) * 260;
         xi[n] = ((n * 23 + 5 * 11) % 47 - 23) * 280;
      end
      run_frame(5, xr, xi, 0, "R3");
      while (frames_done < NFRAMES) @(negedge clk);
      @(negedge clk);
      finished = 1;
      check(exp_re.size() == 0, "R3", "bins left unchecked", exp_re.size(), 0);
      finish_run();
   end

   initial begin
      while (cyc < 20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d frames", frames_done, NFRAMES);
      finished = 1;
      finish_run();
   end
endmodule